// File: doc/BRIEF.md
# IDE Channel Register Window

This block is the memory-mapped front end of a single IDE channel. A host issues 1-, 2- or 4-byte little-endian accesses into a 4 KiB window. The register index is taken from the byte address shifted right by four, so registers sit 16 bytes apart. For each index the block enforces which access sizes are legal.

Legal accesses to the data port, the task-file registers and the control/alternate-status register are forwarded as one request on a simple IDE bus port. That request is held until the device acknowledges it. Two registers are local to the block: a 32-bit timing register and an interrupt status word. The status word mirrors the DMA and disk interrupt lines, and its DMA bit stays set until software clears it with a write-one. The two lines are also passed on, registered, to two interrupt outputs.

Any access to an unmapped index, or with a size that index does not allow, is completed locally. Such a read returns all ones and such a write changes nothing. The device side is a plain request/acknowledge port driven by a model in the bench.

Top module: `ide_regwin`

## Requirements
- R1: The register index is `req_addr[11:4]`. The low four address bits never change which register is reached.
- R2: Index 0x00 (data port) accepts reads of size code 0 (1 byte), 1 (2 bytes) and 2 (4 bytes). 1- and 2-byte reads issue bus kind 0 (16-bit data), and 4-byte reads issue bus kind 1 (32-bit data). The response is the bus word masked to its low 8, 16 or 32 bits.
- R3: The data port accepts only 2- and 4-byte writes. The write data is masked to 16 or 32 bits. A 1-byte data write issues no bus request.
- R4: Indices 0x01 to 0x07 are task-file registers and accept 1-byte accesses only. They issue bus kind 2 with `bus_req_reg` equal to the index. Read data and write data are limited to the low 8 bits.
- R5: Indices 0x08 and 0x16 both reach the control/alternate-status register and accept 1-byte accesses only. They issue bus kind 3 with `bus_req_reg` = 0 and 8-bit data.
- R6: Index 0x20 is a 32-bit timing register that accepts 4-byte accesses only. It resets to 0, and every other access leaves it unchanged.
- R7: Index 0x30 is the interrupt status word and accepts 4-byte accesses only. Bit 31 takes the level of the DMA line whenever that line changes. Bit 30 takes the level of the disk line whenever that line changes. All other bits read 0, and the word resets to 0.
- R8: A legal write to index 0x30 with bit 31 set clears bit 31, even while the DMA line stays high. No other bit of the word is writable. A DMA line change in the same cycle as the clear takes priority.
- R9: A read of an unmapped index, or with a disallowed size (size code 3 is always disallowed), returns 0xFFFFFFFF. Such a write has no effect. Neither issues a bus request.
- R10: `dma_irq_out` and `disk_irq_out` follow `dma_irq_in` and `disk_irq_in` one cycle later.
- R11: Timing: an access that is not forwarded responds with `rsp_valid` one cycle after it is accepted. A forwarded access responds one cycle after the cycle in which `bus_ack` is seen. While a bus request is outstanding, `req_ready` is low and the request fields are held. Write responses carry read data 0.
- R12: While `rst` is high, `bus_rst` is high from the following cycle on, and it drops one cycle after `rst` is released. Reset clears `rsp_valid` and `bus_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| req_wdata | input | 32 | Write data, little-endian, right-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| bus_rst | output | 1 | Reset to the IDE device logic |
| bus_req_valid | output | 1 | Device request, held until acknowledged |
| bus_req_we | output | 1 | Device request direction |
| bus_req_kind | output | 2 | 0 data16, 1 data32, 2 task file, 3 control/status |
| bus_req_reg | output | 3 | Task-file register number |
| bus_req_wdata | output | 32 | Masked write data to the device |
| bus_ack | input | 1 | Device completes the request |
| bus_rdata | input | 32 | Device read data, valid with bus_ack |
| dma_irq_in | input | 1 | DMA interrupt line |
| disk_irq_in | input | 1 | Disk interrupt line |
| dma_irq_out | output | 1 | Registered DMA interrupt |
| disk_irq_out | output | 1 | Registered disk interrupt |

## Verification
The local registers, illegal accesses and unmapped indices must answer exactly one cycle after acceptance. A forwarded access answers one cycle after the device acknowledge, which with the bench's device model comes three cycles after acceptance. Interrupt status and interrupt outputs move one cycle after a line change. The bench drives every input on the falling edge and counts falling edges from acceptance until `rsp_valid` appears, comparing that count against 1 or 3 as well as the data. It also counts device requests to confirm that an ignored access produced none.

// File: rtl/ide_regwin_pkg.sv
package ide_regwin_pkg;

  localparam int WORD_W = 32;
  localparam int BREG_W = 3;

  localparam logic [WORD_W-1:0] MASK_B1 = WORD_W'(32'h0000_00FF);
  localparam logic [WORD_W-1:0] MASK_B2 = WORD_W'(32'h0000_FFFF);
  localparam logic [WORD_W-1:0] MASK_B4 = '1;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_DATA,
    RK_TASK,
    RK_CTRL,
    RK_TIMING,
    RK_IRQ
  } reg_kind_e;

  typedef enum logic [1:0] {
    BK_DATA16 = 2'd0,
    BK_DATA32 = 2'd1,
    BK_TASK   = 2'd2,
    BK_CTRL   = 2'd3
  } bus_kind_e;

  typedef struct packed {
    reg_kind_e          kind;
    logic               ok;
    logic               to_bus;
    bus_kind_e          bkind;
    logic [BREG_W-1:0]  breg;
    logic [WORD_W-1:0]  rmask;
    logic [WORD_W-1:0]  wmask;
  } dec_t;

endpackage

// File: rtl/ide_regwin_decode.sv
module ide_regwin_decode
  import ide_regwin_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int DATA_IDX   = 'h00,
  parameter int TASK_FIRST = 'h01,
  parameter int TASK_LAST  = 'h07,
  parameter int CTRL_IDX_A = 'h08,
  parameter int CTRL_IDX_B = 'h16,
  parameter int TIMING_IDX = 'h20,
  parameter int IRQ_IDX    = 'h30
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       size_i,
  input  logic             we_i,
  output dec_t             dec_o
);

  acc_size_e sz;
  logic      is1, is2, is4;

  assign sz  = acc_size_e'(size_i);
  assign is1 = (sz == SZ_B1);
  assign is2 = (sz == SZ_B2);
  assign is4 = (sz == SZ_B4);

  always_comb begin
    dec_o       = '0;
    dec_o.kind  = RK_NONE;
    dec_o.bkind = BK_DATA16;
    dec_o.rmask = MASK_B4;
    dec_o.wmask = MASK_B4;
    if (idx_i == IDX_W'(DATA_IDX)) begin
      dec_o.kind  = RK_DATA;
      dec_o.ok    = we_i ? (is2 | is4) : (is1 | is2 | is4);
      dec_o.bkind = is4 ? BK_DATA32 : BK_DATA16;
      dec_o.rmask = is1 ? MASK_B1 : (is2 ? MASK_B2 : MASK_B4);
      dec_o.wmask = is4 ? MASK_B4 : MASK_B2;
    end else if (idx_i >= IDX_W'(TASK_FIRST) && idx_i <= IDX_W'(TASK_LAST)) begin
      dec_o.kind  = RK_TASK;
      dec_o.ok    = is1;
      dec_o.bkind = BK_TASK;
      dec_o.breg  = idx_i[BREG_W-1:0];
      dec_o.rmask = MASK_B1;
      dec_o.wmask = MASK_B1;
    end else if (idx_i == IDX_W'(CTRL_IDX_A) || idx_i == IDX_W'(CTRL_IDX_B)) begin
      dec_o.kind  = RK_CTRL;
      dec_o.ok    = is1;
      dec_o.bkind = BK_CTRL;
      dec_o.rmask = MASK_B1;
      dec_o.wmask = MASK_B1;
    end else if (idx_i == IDX_W'(TIMING_IDX)) begin
      dec_o.kind = RK_TIMING;
      dec_o.ok   = is4;
    end else if (idx_i == IDX_W'(IRQ_IDX)) begin
      dec_o.kind = RK_IRQ;
      dec_o.ok   = is4;
    end
    dec_o.to_bus = dec_o.ok &&
                   (dec_o.kind == RK_DATA || dec_o.kind == RK_TASK || dec_o.kind == RK_CTRL);
  end

endmodule

// File: rtl/ide_regwin_busif.sv
module ide_regwin_busif
  import ide_regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              we_i,
  input  bus_kind_e         bkind_i,
  input  logic [BREG_W-1:0] breg_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              bus_valid_o,
  output logic              bus_we_o,
  output logic [1:0]        bus_kind_o,
  output logic [BREG_W-1:0] bus_reg_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  output logic              done_o
);

  logic              valid_q;
  logic              we_q;
  bus_kind_e         kind_q;
  logic [BREG_W-1:0] reg_q;
  logic [WORD_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      kind_q  <= BK_DATA16;
      reg_q   <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      we_q    <= we_i;
      kind_q  <= bkind_i;
      reg_q   <= breg_i;
      wdata_q <= wdata_i;
    end else if (valid_q && bus_ack_i) begin
      valid_q <= 1'b0;
    end
  end

  assign bus_valid_o = valid_q;
  assign bus_we_o    = we_q;
  assign bus_kind_o  = kind_q;
  assign bus_reg_o   = reg_q;
  assign bus_wdata_o = wdata_q;
  assign done_o      = valid_q & bus_ack_i;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && !bus_ack_i) |=> (bus_valid_o && $stable(bus_kind_o) &&
                                     $stable(bus_reg_o) && $stable(bus_wdata_o) &&
                                     $stable(bus_we_o)));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !bus_valid_o);

  // R11
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && bus_ack_i && !start_i) |=> !bus_valid_o);

endmodule

// File: rtl/ide_regwin_irq.sv
module ide_regwin_irq #(
  parameter int             W         = 32,
  parameter int             N         = 2,
  parameter logic [N-1:0]   W1C_LINES = N'(1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] stat_o,
  output logic [N-1:0] lines_o
);

  logic [N-1:0] lvl_q;
  logic [N-1:0] bits_q;
  logic         unused_clr;

  assign unused_clr = ^clr_data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      bits_q <= '0;
    end else begin
      lvl_q <= lines_i;
      for (int g = 0; g < N; g++) begin
        if (lines_i[g] != lvl_q[g]) begin
          bits_q[g] <= lines_i[g];
        end else if (W1C_LINES[g] && clr_i && clr_data_i[W-1-g]) begin
          bits_q[g] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    stat_o = '0;
    for (int g = 0; g < N; g++) begin
      stat_o[W-1-g] = bits_q[g];
    end
  end

  assign lines_o = lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_line_chk
    localparam int POS = W - 1 - g;

    // R7
    rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
      (lines_i[g] && !lines_o[g]) |=> stat_o[POS]);

    // R7
    fall_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (!lines_i[g] && lines_o[g]) |=> !stat_o[POS]);

    // R10
    out_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (lines_i[g] != lines_o[g]) |=> (lines_o[g] == stat_o[POS]));

    if (W1C_LINES[g]) begin : g_w1c
      // R8
      w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (lines_i[g] == lines_o[g] && clr_i && clr_data_i[POS]) |=> !stat_o[POS]);
    end else begin : g_ro
      // R8
      ro_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lines_i[g] == lines_o[g]) |=> $stable(stat_o[POS]));
    end
  end

endmodule

// File: rtl/ide_regwin.sv
module ide_regwin
  import ide_regwin_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int IDX_LO     = 4,
  parameter int DATA_IDX   = 'h00,
  parameter int TASK_FIRST = 'h01,
  parameter int TASK_LAST  = 'h07,
  parameter int CTRL_IDX_A = 'h08,
  parameter int CTRL_IDX_B = 'h16,
  parameter int TIMING_IDX = 'h20,
  parameter int IRQ_IDX    = 'h30,
  parameter int TIMING_RST = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              bus_rst,
  output logic              bus_req_valid,
  output logic              bus_req_we,
  output logic [1:0]        bus_req_kind,
  output logic [BREG_W-1:0] bus_req_reg,
  output logic [WORD_W-1:0] bus_req_wdata,
  input  logic              bus_ack,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              dma_irq_in,
  input  logic              disk_irq_in,
  output logic              dma_irq_out,
  output logic              disk_irq_out
);

  localparam int IDX_W     = ADDR_W - IDX_LO;
  localparam int IRQ_LINES = 2;

  logic [IDX_W-1:0]     idx;
  logic                 unused_lo;
  dec_t                 dec;
  logic                 accept;
  logic                 local_done;
  logic                 bus_start;
  logic                 bus_done;
  logic                 timing_we;
  logic                 irq_clr;
  logic [WORD_W-1:0]    timing_q;
  logic [WORD_W-1:0]    irq_stat;
  logic [WORD_W-1:0]    rmask_q;
  logic [WORD_W-1:0]    local_rd;
  logic                 rsp_valid_q;
  logic [WORD_W-1:0]    rsp_rdata_q;
  logic                 bus_rst_q;
  logic [IRQ_LINES-1:0] irq_lines_in;
  logic [IRQ_LINES-1:0] irq_lines_out;

  assign idx       = req_addr[ADDR_W-1:IDX_LO];
  assign unused_lo = ^req_addr[IDX_LO-1:0];

  ide_regwin_decode #(
    .IDX_W      (IDX_W),
    .DATA_IDX   (DATA_IDX),
    .TASK_FIRST (TASK_FIRST),
    .TASK_LAST  (TASK_LAST),
    .CTRL_IDX_A (CTRL_IDX_A),
    .CTRL_IDX_B (CTRL_IDX_B),
    .TIMING_IDX (TIMING_IDX),
    .IRQ_IDX    (IRQ_IDX)
  ) u_decode (
    .idx_i  (idx),
    .size_i (req_size),
    .we_i   (req_we),
    .dec_o  (dec)
  );

  assign req_ready  = !bus_req_valid;
  assign accept     = req_valid && req_ready;
  assign bus_start  = accept && dec.to_bus;
  assign local_done = accept && !dec.to_bus;
  assign timing_we  = accept && req_we && dec.ok && (dec.kind == RK_TIMING);
  assign irq_clr    = accept && req_we && dec.ok && (dec.kind == RK_IRQ);

  ide_regwin_busif u_busif (
    .clk         (clk),
    .rst         (rst),
    .start_i     (bus_start),
    .we_i        (req_we),
    .bkind_i     (dec.bkind),
    .breg_i      (dec.breg),
    .wdata_i     (req_wdata & dec.wmask),
    .bus_valid_o (bus_req_valid),
    .bus_we_o    (bus_req_we),
    .bus_kind_o  (bus_req_kind),
    .bus_reg_o   (bus_req_reg),
    .bus_wdata_o (bus_req_wdata),
    .bus_ack_i   (bus_ack),
    .done_o      (bus_done)
  );

  assign irq_lines_in = {disk_irq_in, dma_irq_in};

  ide_regwin_irq #(
    .W         (WORD_W),
    .N         (IRQ_LINES),
    .W1C_LINES (IRQ_LINES'(1))
  ) u_irq (
    .clk        (clk),
    .rst        (rst),
    .lines_i    (irq_lines_in),
    .clr_i      (irq_clr),
    .clr_data_i (req_wdata),
    .stat_o     (irq_stat),
    .lines_o    (irq_lines_out)
  );

  assign dma_irq_out  = irq_lines_out[0];
  assign disk_irq_out = irq_lines_out[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      timing_q <= WORD_W'(TIMING_RST);
    end else if (timing_we) begin
      timing_q <= req_wdata;
    end
  end

  always_comb begin
    if (!dec.ok) begin
      local_rd = '1;
    end else if (dec.kind == RK_TIMING) begin
      local_rd = timing_q;
    end else if (dec.kind == RK_IRQ) begin
      local_rd = irq_stat;
    end else begin
      local_rd = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rmask_q <= '0;
    end else if (bus_start) begin
      rmask_q <= dec.rmask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= local_done || bus_done;
      if (bus_done) begin
        rsp_rdata_q <= bus_req_we ? '0 : (bus_rdata & rmask_q);
      end else if (local_done) begin
        rsp_rdata_q <= req_we ? '0 : local_rd;
      end
    end
  end

  always_ff @(posedge clk) begin
    bus_rst_q <= rst;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign bus_rst   = bus_rst_q;

  // R11
  local_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    local_done |=> rsp_valid);

  // R11
  bus_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_ack) |=> rsp_valid);

  // R9
  bad_read_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_we && !dec.ok) |=> (rsp_rdata == '1));

  // R9
  no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    local_done |=> !bus_req_valid);

  // R6
  timing_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(accept && req_we && idx == IDX_W'(TIMING_IDX) && req_size == 2'd2) |=> $stable(timing_q));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept && !(bus_req_valid && bus_ack)) |=> !rsp_valid);

endmodule

// File: tb/test_ide_regwin.sv
module test_ide_regwin;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic        req_we;
  logic [11:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        bus_rst;
  logic        bus_req_valid;
  logic        bus_req_we;
  logic [1:0]  bus_req_kind;
  logic [2:0]  bus_req_reg;
  logic [31:0] bus_req_wdata;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic        dma_irq_in;
  logic        disk_irq_in;
  logic        dma_irq_out;
  logic        disk_irq_out;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic [31:0] m_timing = 32'h0;
  logic        m_b31 = 1'b0;
  logic        m_b30 = 1'b0;

  // device model
  int          nreq = 0;
  logic [1:0]  last_kind;
  logic [2:0]  last_reg;
  logic        last_we;
  logic [31:0] last_wdata;

  always #5 clk = ~clk;

  ide_regwin i_ide_regwin (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_we        (req_we),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .bus_rst       (bus_rst),
    .bus_req_valid (bus_req_valid),
    .bus_req_we    (bus_req_we),
    .bus_req_kind  (bus_req_kind),
    .bus_req_reg   (bus_req_reg),
    .bus_req_wdata (bus_req_wdata),
    .bus_ack       (bus_ack),
    .bus_rdata     (bus_rdata),
    .dma_irq_in    (dma_irq_in),
    .disk_irq_in   (disk_irq_in),
    .dma_irq_out   (dma_irq_out),
    .disk_irq_out  (disk_irq_out)
  );

  function automatic logic [31:0] dev_word(input logic [1:0] k, input logic [2:0] r);
    return {8'hA5, 5'd0, r, 4'h7, 2'b00, k, 8'hC3};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
    end else begin
      bus_ack <= bus_req_valid && !bus_ack;
    end
    bus_rdata <= dev_word(bus_req_kind, bus_req_reg);
    if (!rst && bus_req_valid && !bus_ack) begin
      nreq       <= nreq + 1;
      last_kind  <= bus_req_kind;
      last_reg   <= bus_req_reg;
      last_we    <= bus_req_we;
      last_wdata <= bus_req_wdata;
    end
  end

  // 0 none, 1 data, 2 task, 3 ctrl, 4 timing, 5 irq
  function automatic int kind_of(input logic [7:0] idx);
    if (idx == 8'h00) return 1;
    if (idx >= 8'h01 && idx <= 8'h07) return 2;
    if (idx == 8'h08 || idx == 8'h16) return 3;
    if (idx == 8'h20) return 4;
    if (idx == 8'h30) return 5;
    return 0;
  endfunction

  function automatic bit ok_of(input logic [7:0] idx, input logic [1:0] sz, input bit we);
    case (kind_of(idx))
      1: return we ? (sz == 2'd1 || sz == 2'd2) : (sz != 2'd3);
      2, 3: return sz == 2'd0;
      4, 5: return sz == 2'd2;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit to_bus(input logic [7:0] idx, input logic [1:0] sz, input bit we);
    int k = kind_of(idx);
    return ok_of(idx, sz, we) && (k >= 1 && k <= 3);
  endfunction

  function automatic logic [1:0] exp_bkind(input logic [7:0] idx, input logic [1:0] sz);
    case (kind_of(idx))
      1: return (sz == 2'd2) ? 2'd1 : 2'd0;
      2: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [2:0] exp_breg(input logic [7:0] idx);
    return (kind_of(idx) == 2) ? idx[2:0] : 3'd0;
  endfunction

  function automatic logic [31:0] size_mask(input logic [7:0] idx, input logic [1:0] sz);
    if (kind_of(idx) != 1) return 32'h0000_00FF;
    if (sz == 2'd0) return 32'h0000_00FF;
    if (sz == 2'd1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [7:0] idx, input logic [1:0] sz,
                                            input bit we);
    if (we) return 32'h0;
    if (!ok_of(idx, sz, we)) return 32'hFFFF_FFFF;
    case (kind_of(idx))
      4: return m_timing;
      5: return {m_b31, m_b30, 30'h0};
      default: return dev_word(exp_bkind(idx, sz), exp_breg(idx)) & size_mask(idx, sz);
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] idx, input logic [1:0] sz, input bit we);
    if (!ok_of(idx, sz, we)) return "R9";
    case (kind_of(idx))
      1: return we ? "R3" : "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic [11:0] a, input logic [1:0] sz, input bit we,
                      input logic [31:0] wd, input bit flip_dma, input string tag);
    logic [7:0]  idx   = a[11:4];
    bit          fwd   = to_bus(idx, sz, we);
    logic [31:0] exp   = exp_rdata(idx, sz, we);
    int          n0    = nreq;
    int          lat;
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_size  = sz;
    req_wdata = wd;
    if (flip_dma) dma_irq_in = ~dma_irq_in;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " R11 latency"}, 32'(lat), fwd ? 32'd3 : 32'd1);
    chk({tag, " rdata"}, rsp_rdata, exp);
    chk({tag, " R9 bus request count"}, 32'(nreq - n0), fwd ? 32'd1 : 32'd0);
    if (fwd) begin
      chk({tag, " bus kind"}, 32'(last_kind), 32'(exp_bkind(idx, sz)));
      chk({tag, " bus reg"}, 32'(last_reg), 32'(exp_breg(idx)));
      chk({tag, " bus we"}, 32'(last_we), 32'(we));
      if (we) chk({tag, " bus wdata"}, last_wdata, wd & size_mask(idx, sz));
    end
    if (we && ok_of(idx, sz, we) && kind_of(idx) == 4) m_timing = wd;
    if (we && ok_of(idx, sz, we) && kind_of(idx) == 5 && wd[31]) m_b31 = 1'b0;
    if (flip_dma) m_b31 = dma_irq_in;
  endtask

  task automatic set_line(input int which, input bit val);
    @(negedge clk);
    if (which == 0) begin
      if (dma_irq_in != val) m_b31 = val;
      dma_irq_in = val;
    end else begin
      if (disk_irq_in != val) m_b30 = val;
      disk_irq_in = val;
    end
    @(negedge clk);
    chk("R10 dma out", 32'(dma_irq_out), 32'(dma_irq_in));
    chk("R10 disk out", 32'(disk_irq_out), 32'(disk_irq_in));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R11: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst         = 1'b1;
    req_valid   = 1'b0;
    req_we      = 1'b0;
    req_addr    = '0;
    req_size    = '0;
    req_wdata   = '0;
    dma_irq_in  = 1'b0;
    disk_irq_in = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 bus_rst in reset", 32'(bus_rst), 32'd1);
    chk("R12 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R12 bus_req_valid in reset", 32'(bus_req_valid), 32'd0);
    chk("R12 req_ready in reset", 32'(req_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 bus_rst released", 32'(bus_rst), 32'd0);

    // R6 / R7 reset values
    xact(12'h200, 2'd2, 1'b0, 32'h0, 1'b0, "R6 timing reset");
    xact(12'h300, 2'd2, 1'b0, 32'h0, 1'b0, "R7 irq reset");
    // R6 write/read, illegal size ignored
    xact(12'h200, 2'd2, 1'b1, 32'hDEAD_BEEF, 1'b0, "R6 timing write");
    xact(12'h204, 2'd2, 1'b0, 32'h0, 1'b0, "R6 timing read");
    xact(12'h200, 2'd1, 1'b1, 32'h1234_5678, 1'b0, "R9 timing short write");
    xact(12'h200, 2'd1, 1'b0, 32'h0, 1'b0, "R9 timing short read");
    xact(12'h200, 2'd2, 1'b0, 32'h0, 1'b0, "R6 timing unchanged");
    // R2 data reads
    xact(12'h000, 2'd0, 1'b0, 32'h0, 1'b0, "R2 data byte read");
    xact(12'h000, 2'd1, 1'b0, 32'h0, 1'b0, "R2 data half read");
    xact(12'h00F, 2'd2, 1'b0, 32'h0, 1'b0, "R2 data word read");
    // R3 data writes
    xact(12'h000, 2'd0, 1'b1, 32'h1111_22AB, 1'b0, "R3 data byte write ignored");
    xact(12'h000, 2'd1, 1'b1, 32'h1111_2233, 1'b0, "R3 data half write");
    xact(12'h000, 2'd2, 1'b1, 32'h4455_6677, 1'b0, "R3 data word write");
    // R4 task file
    xact(12'h030, 2'd0, 1'b0, 32'h0, 1'b0, "R4 task3 read");
    xact(12'h07A, 2'd0, 1'b1, 32'hFFFF_FF5E, 1'b0, "R4 task7 write");
    xact(12'h030, 2'd1, 1'b0, 32'h0, 1'b0, "R9 task half read");
    // R1 stride: same register at different low nibbles
    xact(12'h010, 2'd0, 1'b0, 32'h0, 1'b0, "R1 task1 at +0");
    xact(12'h01F, 2'd0, 1'b0, 32'h0, 1'b0, "R1 task1 at +F");
    // R5 control aliases
    xact(12'h080, 2'd0, 1'b0, 32'h0, 1'b0, "R5 ctrl A read");
    xact(12'h16C, 2'd0, 1'b1, 32'h0000_0006, 1'b0, "R5 ctrl B write");
    xact(12'h160, 2'd2, 1'b0, 32'h0, 1'b0, "R9 ctrl word read");
    // R9 unmapped and illegal size code
    xact(12'h400, 2'd2, 1'b0, 32'h0, 1'b0, "R9 unmapped read");
    xact(12'hFF0, 2'd0, 1'b1, 32'h0, 1'b0, "R9 unmapped write");
    xact(12'h000, 2'd3, 1'b0, 32'h0, 1'b0, "R9 size3 read");

    // R7 / R8 interrupt status
    set_line(0, 1'b1);
    xact(12'h300, 2'd2, 1'b0, 32'h0, 1'b0, "R7 dma high");
    xact(12'h300, 2'd2, 1'b1, 32'h7FFF_FFFF, 1'b0, "R8 write without bit31");
    xact(12'h300, 2'd2, 1'b0, 32'h0, 1'b0, "R8 bit31 kept");
    xact(12'h300, 2'd2, 1'b1, 32'h8000_0000, 1'b0, "R8 clear");
    xact(12'h300, 2'd2, 1'b0, 32'h0, 1'b0, "R8 cleared with line high");
    set_line(1, 1'b1);
    xact(12'h300, 2'd2, 1'b0, 32'h0, 1'b0, "R7 disk high");
    xact(12'h300, 2'd2, 1'b1, 32'hFFFF_FFFF, 1'b0, "R8 disk not writable");
    xact(12'h300, 2'd2, 1'b0, 32'h0, 1'b0, "R8 disk bit kept");
    set_line(0, 1'b0);
    set_line(1, 1'b0);
    xact(12'h300, 2'd2, 1'b0, 32'h0, 1'b0, "R7 lines low");
    // R8 rise in same cycle as clear: edge wins
    xact(12'h300, 2'd2, 1'b1, 32'h8000_0000, 1'b1, "R8 rise with clear");
    xact(12'h300, 2'd2, 1'b0, 32'h0, 1'b0, "R8 rise wins");
    xact(12'h300, 2'd1, 1'b1, 32'h8000_0000, 1'b0, "R9 irq half write");
    xact(12'h300, 2'd2, 1'b0, 32'h0, 1'b0, "R9 irq unchanged");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  idx;
      logic [11:0] a;
      logic [1:0]  sz;
      bit          we;
      logic [31:0] wd;
      int          r = int'($urandom % 16);
      if (r == 0) set_line(0, bit'($urandom % 2));
      if (r == 1) set_line(1, bit'($urandom % 2));
      case ($urandom % 8)
        0: idx = 8'h00;
        1: idx = 8'(1 + $urandom % 7);
        2: idx = 8'h08;
        3: idx = 8'h16;
        4: idx = 8'h20;
        5: idx = 8'h30;
        default: idx = 8'($urandom);
      endcase
      a  = {idx, 4'($urandom)};
      sz = 2'($urandom);
      if ($urandom % 4 != 0 && kind_of(idx) >= 4) sz = 2'd2;
      if ($urandom % 4 != 0 && (kind_of(idx) == 2 || kind_of(idx) == 3)) sz = 2'd0;
      we = bit'($urandom % 2);
      wd = $urandom;
      xact(a, sz, we, wd, 1'b0, {"rand ", req_of(idx, sz, we)});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule